// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block sits next to the ECC checker of a memory controller. The checker reports correctable (single-bit) and uncorrectable (multi-bit) events. For each event it also gives the failing data word, its check bits or syndrome, and the failing address. The unit turns those events into sticky status flags. It records the details of the first failure and raises a level interrupt toward the processor. Software reaches it through a plain 32-bit register port with word addresses and a combinational read path.

Correctable errors do not interrupt one by one. A software-loaded threshold paces them: a counter advances on every accepted single-bit event. The flag rises only when the counter reaches the threshold, and the counter then restarts from zero. Uncorrectable errors set their flag at once. The capture registers follow accepted events only while no flag is set. They therefore freeze on the first flagged failure until software clears the status.

The unit also holds error-injection masks for the write path. When injection is on, it XORs the masks into the write data and check bits on their way to memory.

Top module: `ecc_err_capture`

## Requirements
- R1: The status register (word address 0) holds the single-bit flag in bit 0 and the multi-bit flag in bit 1. Writing a 1 to a flag bit clears it, writing 0 leaves it, and writing 0xFFFFFFFF clears both.
- R2: The counter register (word address 3) holds the threshold in bits 23:16 and the single-bit event count in bits 7:0, and both are software writable. Each accepted single-bit event adds one to the count. When the incremented count reaches or passes the threshold, the event sets status bit 0 and the count returns to 0. Writing 0x00010000 sets one error per flag.
- R3: An accepted multi-bit event sets status bit 1 on the next clock edge, whatever the counter holds.
- R4: The suppress register (word address 2) resets to 0x3. Bit 0 blocks single-bit events and bit 1 blocks multi-bit events. A blocked event changes no flag, no count and no capture register.
- R5: The capture registers load on every accepted event while the status register is zero, and hold their value while any flag is set. The registers are: data high (word 5), data low (word 6), syndrome (word 7), address low (word 8) and address high (word 9).
- R6: Bit 0 of the config register (word address 4) selects a 32-bit data bus when 1. The captured syndrome then keeps all 16 bits. When the bit is 0 (64-bit bus), only bits 7:0 are kept and bits 15:8 read as 0.
- R7: The interrupt enable register (word address 1) enables the single-bit flag with bit 0 and the multi-bit flag with bit 1. irq_o is high exactly when some set flag has its enable bit set.
- R8: The injection registers are the data high mask (word 10), the data low mask (word 11) and the control word (word 12). In the control word, bits 7:0 are the check-bit mask and bit 8 is the enable. When the enable is set, inj_data_o = wr_data_i XOR the masks and inj_chk_o = wr_chk_i XOR the check mask. Otherwise both outputs pass their inputs through unchanged.
- R9: If a flag is set by an event in the same cycle that software writes 1 to clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| sbe_i | input | 1 | Single-bit error event from the checker |
| mbe_i | input | 1 | Multi-bit error event from the checker |
| err_data_i | input | 64 | Failing data word |
| err_chk_i | input | 16 | Failing check bits / syndrome |
| err_addr_i | input | 64 | Failing address |
| wr_data_i | input | 64 | Write data toward memory |
| wr_chk_i | input | 8 | Write check bits toward memory |
| inj_data_o | output | 64 | Write data after injection |
| inj_chk_o | output | 8 | Check bits after injection |
| irq_o | output | 1 | Error interrupt |

## Verification
The bench uses the default parameters: a 64-bit data word, a 64-bit address, a 16-bit syndrome and an 8-bit count and threshold. At these values the 64-bit capture is split across register pairs, so both halves and the narrowed syndrome can be read back. The 8-bit counter means small thresholds such as 1 and 3 give every rollover within a few events. The injection table covers enabled and disabled masks on both data halves and on the check bits.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] A_STATUS  = 4'd0;
  localparam logic [REG_AW-1:0] A_INT_EN  = 4'd1;
  localparam logic [REG_AW-1:0] A_SUPPR   = 4'd2;
  localparam logic [REG_AW-1:0] A_SBE_CNT = 4'd3;
  localparam logic [REG_AW-1:0] A_CFG     = 4'd4;
  localparam logic [REG_AW-1:0] A_CAP_DH  = 4'd5;
  localparam logic [REG_AW-1:0] A_CAP_DL  = 4'd6;
  localparam logic [REG_AW-1:0] A_CAP_SYN = 4'd7;
  localparam logic [REG_AW-1:0] A_CAP_AL  = 4'd8;
  localparam logic [REG_AW-1:0] A_CAP_AH  = 4'd9;
  localparam logic [REG_AW-1:0] A_INJ_H   = 4'd10;
  localparam logic [REG_AW-1:0] A_INJ_L   = 4'd11;
  localparam logic [REG_AW-1:0] A_INJ_C   = 4'd12;

  // flag bit positions, shared by status, enable and suppress registers
  localparam int unsigned F_SBE = 0;
  localparam int unsigned F_MBE = 1;
  localparam int unsigned NFLAG = 2;
endpackage

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned THR_LSB = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] thr_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, thr_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // software write takes priority over a same-cycle event
  assign hit_o   = event_i && !wr_i && (cnt_inc >= {1'b0, thr_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      thr_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i[CNT_W-1:0];
      thr_q <= wdata_i[THR_LSB +: CNT_W];
    end else if (event_i) begin
      cnt_q <= hit_o ? '0 : cnt_inc[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/ecc_cap_regs.sv
module ecc_cap_regs #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SYN_W  = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              narrow_bus_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic [SYN_W-1:0]  syn_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SYN_W-1:0] syn_mask, syn_keep;

  // a 64-bit bus keeps only the low syndrome byte
  assign syn_mask = narrow_bus_i ? '1 : {{(SYN_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign syn_keep = syn_i & syn_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      syn_o  <= '0;
      addr_o <= '0;
    end else if (load_i) begin
      data_o <= data_i;
      syn_o  <= syn_keep;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/ecc_inject.sv
module ecc_inject #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_mask_i,
  input  logic [CHK_W-1:0]  chk_mask_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o
);
  assign data_o = data_i ^ (data_mask_i & {DATA_W{en_i}});
  assign chk_o  = chk_i  ^ (chk_mask_i  & {CHK_W{en_i}});
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_err_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SYN_W  = 16,
  parameter int unsigned CHK_W  = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic [SYN_W-1:0]  err_chk_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CHK_W-1:0]  wr_chk_i,
  output logic [DATA_W-1:0] inj_data_o,
  output logic [CHK_W-1:0]  inj_chk_o,
  output logic              irq_o
);
  localparam int unsigned HALF_D = DATA_W / 2;
  localparam int unsigned HALF_A = ADDR_W / 2;
  localparam int unsigned THR_LSB = 16;

  logic [NFLAG-1:0] status_q, int_en_q, suppr_q, flag_set, flag_clr;
  logic             narrow_q;
  logic [DATA_W-1:0] inj_mask_q;
  logic [CHK_W-1:0]  inj_chk_q;
  logic              inj_en_q;
  logic              sbe_acc, mbe_acc, sbe_hit, cap_load;
  logic [CNT_W-1:0]  sbe_cnt, sbe_thr;
  logic [DATA_W-1:0] cap_data;
  logic [SYN_W-1:0]  cap_syn;
  logic [ADDR_W-1:0] cap_addr;

  function automatic logic wr_hit(input logic [3:0] a);
    return reg_we_i && (reg_addr_i == a);
  endfunction

  assign sbe_acc  = sbe_i && !suppr_q[F_SBE];
  assign mbe_acc  = mbe_i && !suppr_q[F_MBE];
  assign cap_load = (sbe_acc || mbe_acc) && (status_q == '0);

  ecc_sbe_counter #(.CNT_W(CNT_W), .THR_LSB(THR_LSB)) u_sbe_cnt (
    .clk_i, .rst_ni,
    .event_i (sbe_acc),
    .wr_i    (wr_hit(A_SBE_CNT)),
    .wdata_i (reg_wdata_i),
    .cnt_o   (sbe_cnt),
    .thr_o   (sbe_thr),
    .hit_o   (sbe_hit)
  );

  ecc_cap_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYN_W(SYN_W), .NARROW_W(CHK_W)) u_cap (
    .clk_i, .rst_ni,
    .load_i       (cap_load),
    .narrow_bus_i (narrow_q),
    .data_i       (err_data_i),
    .syn_i        (err_chk_i),
    .addr_i       (err_addr_i),
    .data_o       (cap_data),
    .syn_o        (cap_syn),
    .addr_o       (cap_addr)
  );

  ecc_inject #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_inj (
    .en_i        (inj_en_q),
    .data_mask_i (inj_mask_q),
    .chk_mask_i  (inj_chk_q),
    .data_i      (wr_data_i),
    .chk_i       (wr_chk_i),
    .data_o      (inj_data_o),
    .chk_o       (inj_chk_o)
  );

  always_comb begin
    flag_set        = '0;
    flag_set[F_SBE] = sbe_hit;
    flag_set[F_MBE] = mbe_acc;
    flag_clr        = wr_hit(A_STATUS) ? reg_wdata_i[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q   <= '0;
      int_en_q   <= '0;
      suppr_q    <= '1;
      narrow_q   <= 1'b0;
      inj_mask_q <= '0;
      inj_chk_q  <= '0;
      inj_en_q   <= 1'b0;
    end else begin
      status_q <= (status_q & ~flag_clr) | flag_set;  // set wins
      if (wr_hit(A_INT_EN)) int_en_q <= reg_wdata_i[NFLAG-1:0];
      if (wr_hit(A_SUPPR))  suppr_q  <= reg_wdata_i[NFLAG-1:0];
      if (wr_hit(A_CFG))    narrow_q <= reg_wdata_i[0];
      if (wr_hit(A_INJ_H))  inj_mask_q[DATA_W-1:HALF_D] <= reg_wdata_i[HALF_D-1:0];
      if (wr_hit(A_INJ_L))  inj_mask_q[HALF_D-1:0]      <= reg_wdata_i[HALF_D-1:0];
      if (wr_hit(A_INJ_C)) begin
        inj_chk_q <= reg_wdata_i[CHK_W-1:0];
        inj_en_q  <= reg_wdata_i[CHK_W];
      end
    end
  end

  assign irq_o = |(status_q & int_en_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_STATUS:  reg_rdata_o[NFLAG-1:0] = status_q;
      A_INT_EN:  reg_rdata_o[NFLAG-1:0] = int_en_q;
      A_SUPPR:   reg_rdata_o[NFLAG-1:0] = suppr_q;
      A_SBE_CNT: begin
        reg_rdata_o[CNT_W-1:0]          = sbe_cnt;
        reg_rdata_o[THR_LSB +: CNT_W]   = sbe_thr;
      end
      A_CFG:     reg_rdata_o[0]         = narrow_q;
      A_CAP_DH:  reg_rdata_o            = cap_data[DATA_W-1:HALF_D];
      A_CAP_DL:  reg_rdata_o            = cap_data[HALF_D-1:0];
      A_CAP_SYN: reg_rdata_o[SYN_W-1:0] = cap_syn;
      A_CAP_AL:  reg_rdata_o            = cap_addr[HALF_A-1:0];
      A_CAP_AH:  reg_rdata_o            = cap_addr[ADDR_W-1:HALF_A];
      A_INJ_H:   reg_rdata_o            = inj_mask_q[DATA_W-1:HALF_D];
      A_INJ_L:   reg_rdata_o            = inj_mask_q[HALF_D-1:0];
      A_INJ_C:   reg_rdata_o[CHK_W:0]   = {inj_en_q, inj_chk_q};
      default:   reg_rdata_o            = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [3:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        sbe_i,
  input logic        mbe_i,
  input logic [1:0]  status_q,
  input logic [1:0]  suppr_q,
  input logic [7:0]  sbe_cnt,
  input logic [7:0]  sbe_thr,
  input logic [63:0] cap_data,
  input logic        irq_o
);
  // R3: accepted multi-bit event sets its flag next cycle
  p_mbe_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbe_i && !suppr_q[1]) |=> status_q[1]);

  // R4: a single-bit flag only rises after an unsuppressed event
  p_sbe_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[0]) |-> $past(sbe_i && !suppr_q[0]));

  // R5: capture frozen while any flag is set
  p_cap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q != 2'b00) |=> $stable(cap_data));

  // R7: no interrupt without a flag
  p_irq_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q != 2'b00));

  // R2: below threshold the count advances by one
  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_i && !suppr_q[0] && !(reg_we_i && reg_addr_i == 4'd3) &&
     ({1'b0, sbe_cnt} + 9'd1 < {1'b0, sbe_thr}))
    |=> (sbe_cnt == $past(sbe_cnt) + 8'd1));

  // R1: all-ones clear with no event empties the status
  p_clear_all_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd0 && reg_wdata_i == 32'hFFFF_FFFF && !sbe_i && !mbe_i)
    |=> (status_q == 2'b00));
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sbe_i       (sbe_i),
  .mbe_i       (mbe_i),
  .status_q    (status_q),
  .suppr_q     (suppr_q),
  .sbe_cnt     (sbe_cnt),
  .sbe_thr     (sbe_thr),
  .cap_data    (cap_data),
  .irq_o       (irq_o)
);

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        sbe_i = 1'b0, mbe_i = 1'b0;
  logic [63:0] err_data_i = '0, err_addr_i = '0, wr_data_i = '0;
  logic [15:0] err_chk_i = '0;
  logic [7:0]  wr_chk_i = '0;
  logic [63:0] inj_data_o;
  logic [7:0]  inj_chk_o;
  logic        irq_o;

  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  ecc_err_capture u_dut (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .sbe_i, .mbe_i, .err_data_i, .err_chk_i, .err_addr_i,
    .wr_data_i, .wr_chk_i, .inj_data_o, .inj_chk_o, .irq_o
  );

  // injection table: data mask, check mask, enable, write data, write check bits
  localparam int NV = 4;
  localparam logic [63:0] V_MASK [NV] = '{64'h0, 64'h8000_0000_0000_0001,
                                          64'hFFFF_0000_0000_FFFF, 64'h1234_5678_9ABC_DEF0};
  localparam logic [7:0]  V_CMSK [NV] = '{8'h00, 8'h01, 8'hA5, 8'hFF};
  localparam logic        V_EN   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [63:0] V_DATA [NV] = '{64'hDEAD_BEEF_0000_1111, 64'h0,
                                          64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [7:0]  V_CHK  [NV] = '{8'h3C, 8'h00, 8'h5A, 8'h77};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic ev(input logic s, input logic m, input logic [63:0] d,
                    input logic [15:0] c, input logic [63:0] a);
    @(negedge clk);
    sbe_i = s; mbe_i = m; err_data_i = d; err_chk_i = c; err_addr_i = a;
    @(negedge clk);
    sbe_i = 1'b0; mbe_i = 1'b0;
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // reset state
    rd(4'd0, d);  check("R1 reset status", d, 0);
    rd(4'd2, d);  check("R4 reset suppress", d, 32'h3);
    rd(4'd3, d);  check("R2 reset counter", d, 0);
    check("R7 reset irq", irq_o, 0);

    // suppressed events are ignored
    ev(1, 1, 64'hAAAA, 16'h11, 64'h55);
    rd(4'd0, d);  check("R4 suppressed status", d, 0);
    rd(4'd3, d);  check("R4 suppressed count", d, 0);
    rd(4'd6, d);  check("R4 suppressed capture", d, 0);

    wr(4'd2, 32'h0);
    wr(4'd1, 32'h3);
    wr(4'd3, 32'h0003_0000);
    rd(4'd3, d);  check("R2 threshold write", d, 32'h0003_0000);

    ev(1, 0, 64'h1111_0000_0000_000A, 16'h0A, 64'h10);
    ev(1, 0, 64'h2222_0000_0000_000B, 16'h0B, 64'h20);
    rd(4'd3, d);  check("R2 count two", d, 32'h0003_0002);
    rd(4'd0, d);  check("R2 no flag below threshold", d, 0);
    rd(4'd6, d);  check("R5 capture follows while clear", d, 32'h0000_000B);
    ev(1, 0, 64'h3333_0000_0000_000C, 16'hFF0C, 64'h7_0000_0030);
    rd(4'd0, d);  check("R2 flag at threshold", d, 32'h1);
    rd(4'd3, d);  check("R2 count rolls to zero", d, 32'h0003_0000);
    check("R7 irq on sbe", irq_o, 1);
    rd(4'd7, d);  check("R6 wide bus syndrome byte", d, 32'h0C);
    ev(1, 0, 64'h4444_0000_0000_000D, 16'h0D, 64'h40);
    rd(4'd5, d);  check("R5 frozen data high", d, 32'h3333_0000);
    rd(4'd9, d);  check("R5 frozen address high", d, 32'h7);

    wr(4'd0, 32'h1);
    rd(4'd0, d);  check("R1 write one clears", d, 0);
    check("R7 irq cleared", irq_o, 0);

    // multi-bit with narrow bus
    wr(4'd4, 32'h1);
    ev(0, 1, 64'h5555_6666_7777_8888, 16'hABCD, 64'h9_0000_1000);
    rd(4'd0, d);  check("R3 mbe flag", d, 32'h2);
    rd(4'd7, d);  check("R6 narrow bus syndrome", d, 32'hABCD);
    rd(4'd8, d);  check("R5 capture address low", d, 32'h1000);
    wr(4'd1, 32'h1);
    check("R7 mbe not enabled", irq_o, 0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d);  check("R1 all ones clears", d, 0);

    // same-cycle set and clear: threshold 1
    wr(4'd3, 32'h0001_0000);
    @(negedge clk);
    sbe_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 4'd0; reg_wdata_i = 32'h1;
    @(negedge clk);
    sbe_i = 1'b0; reg_we_i = 1'b0;
    rd(4'd0, d);  check("R9 set wins over clear", d, 32'h1);

    // injection table
    for (int i = 0; i < NV; i++) begin
      wr(4'd10, V_MASK[i][63:32]);
      wr(4'd11, V_MASK[i][31:0]);
      wr(4'd12, {23'b0, V_EN[i], V_CMSK[i]});
      @(negedge clk);
      wr_data_i = V_DATA[i]; wr_chk_i = V_CHK[i];
      #1;
      check("R8 inject data", inj_data_o, V_EN[i] ? (V_DATA[i] ^ V_MASK[i]) : V_DATA[i]);
      check("R8 inject check bits", {56'b0, inj_chk_o},
            {56'b0, V_EN[i] ? (V_CHK[i] ^ V_CMSK[i]) : V_CHK[i]});
    end

    summary();
  end
endmodule